// File: doc/BRIEF.md
# Configuration Register Slave with Enable Pulses

This block is a register target on a memory-mapped bus that uses a request, grant and valid handshake. The bus has a 20-bit byte address, 32-bit data and four byte enables. The slave owns a 1 MB window and decodes every address bit. Inside that window it holds four sets of configuration:

- **Port address registers**: one per memory port, each holding a 20-bit address.
- **Multiplier control words**: one per multiplier.
- **Memory-mode words**: one per math unit. Each carries a write-data source select and a lane-width mode (32, 16 or 8 bit) for each of its three RAMs.
- **Enable-pulse words**: one per multiplier. They are write-only. Writing a 1 into bit 0 gives the matching multiplier a clock enable that lasts exactly one cycle. These words never hold state and always read as zero.

The bus side is already synchronous to this block's clock. Grant is given in the same cycle as the request. The acknowledge, and any read data, follow one cycle later. Because of this, a master can issue one access every cycle. The register contents leave the block as flat vectors for the consuming datapath.

Top module: `ctlreg_slave`

## Requirements
- R1: After a synchronous reset, every stored register is zero, `valid` is 0, `rdata` is 0 and no enable pulse is active.
- R2: `gnt` is high in exactly the cycles in which `req` is high.
- R3: `valid` is high in the cycle right after each cycle in which `req` was high, for reads and for writes. At all other times it is low. `rdata` is zero except in the acknowledge cycle of a read.
- R4: Port address register k sits at byte offset 0x00+4k. It stores write bits 19:0, reads back in bits 19:0 with bits 31:20 as zero, and drives `port_addr_o[20k+19:20k]`.
- R5: Multiplier control word k sits at offset 0x10+4k. It stores all 32 bits, reads back, and drives `mul_ctl_o[32k+31:32k]`.
- R6: Memory-mode word u sits at offset 0x20+4u. Its 15 bits drive `ram_ctl_o[15u+14:15u]`, and bits 31:15 read as zero. The layout is:
  - bit 14: coefficient write source
  - bit 13: second-operand write source
  - bit 12: first-operand write source
  - bits 11:10 and 9:8: coefficient write and read widths
  - bits 7:6 and 5:4: second-operand write and read widths
  - bits 3:2 and 1:0: first-operand write and read widths

  A width field uses 00 for 32-bit, 01 for 16-bit and 10 for 8-bit.
- R7: On a write, byte enable `be[i]` decides whether bits 8i+7:8i of the target register take the new data. A lane whose enable is low keeps its old value.
- R8: A write to offset 0x30+4k with `be[0]=1` and `wdata[0]=1` raises `mul_ce_o[k]`, and only that bit, in the acknowledge cycle of the write, for that one cycle. If `wdata[0]=0` or `be[0]=0`, the write raises no pulse.
- R9: Reads of the enable-pulse offsets 0x30 to 0x3C return zero.
- R10: Writes to any other offset (0x28, 0x2C, 0x40 and above) change no register and raise no pulse. Reads of those offsets return zero.
- R11: Decode compares address bits 19:2 in full, so 0x10020 or 0x10030 do not alias onto 0x20 or 0x30. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request |
| wen | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Byte address within the window |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte-lane enables |
| gnt | output | 1 | Grant, same cycle as request |
| valid | output | 1 | Acknowledge, one cycle after request |
| rdata | output | 32 | Read data, qualified by valid |
| port_addr_o | output | 80 | Port address registers, 20 bits each |
| mul_ctl_o | output | 128 | Multiplier control words, 32 bits each |
| ram_ctl_o | output | 30 | Memory-mode words, 15 bits each |
| mul_ce_o | output | 4 | One-cycle enable pulse per multiplier |

## Verification
The bench builds the block with its default parameters: four ports, four multipliers, two math units, 20-bit port addresses and full 32-bit multiplier words. Under these values the enable-pulse base lands at 0x30, which leaves the unmapped gap at 0x28 and 0x2C. It also makes every byte lane of the multiplier word visible for byte-enable checks.

These values make it possible to probe the gap, the alias addresses above 64 KB, and the truncation of port addresses above bit 19. They also allow pulses on every multiplier bit to be separated from one another. Back-to-back accesses show that a read issued in the cycle after a write already sees the new value.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int BUS_AW     = 20;
    localparam int BUS_DW     = 32;
    localparam int BUS_BW     = BUS_DW / 8;
    localparam int WORD_BYTES = 4;
    localparam int CE_ALIGN   = 16;

    typedef enum logic [1:0] {
        LANE_32  = 2'b00,
        LANE_16  = 2'b01,
        LANE_8   = 2'b10,
        LANE_RSV = 2'b11
    } lane_mode_e;

    // Field order fixes the bit positions seen by the consuming math unit.
    typedef struct packed {
        logic       coef_wsel;
        logic       opb_wsel;
        logic       opa_wsel;
        lane_mode_e coef_wmode;
        lane_mode_e coef_rmode;
        lane_mode_e opb_wmode;
        lane_mode_e opb_rmode;
        lane_mode_e opa_wmode;
        lane_mode_e opa_rmode;
    } ram_ctl_t;

    localparam int RAM_CTL_W = $bits(ram_ctl_t);

    typedef struct packed {
        logic              wr;
        logic [BUS_AW-1:0] offs;
        logic [BUS_DW-1:0] wdata;
        logic [BUS_BW-1:0] be;
    } bus_acc_t;

    function automatic logic [BUS_DW-1:0] lane_merge(
        input logic [BUS_DW-1:0] cur,
        input logic [BUS_DW-1:0] nxt,
        input logic [BUS_BW-1:0] be
    );
        logic [BUS_DW-1:0] res;
        for (int l = 0; l < BUS_BW; l++) begin
            res[l*8 +: 8] = be[l] ? nxt[l*8 +: 8] : cur[l*8 +: 8];
        end
        return res;
    endfunction

    function automatic int mul_base(input int n_port);
        return n_port * WORD_BYTES;
    endfunction

    function automatic int ram_base(input int n_port, input int n_mul);
        return mul_base(n_port) + n_mul * WORD_BYTES;
    endfunction

    function automatic int ce_base(input int n_port, input int n_mul, input int n_unit);
        return ((ram_base(n_port, n_mul) + n_unit * WORD_BYTES + CE_ALIGN - 1) / CE_ALIGN) * CE_ALIGN;
    endfunction

    function automatic logic [BUS_AW-1:0] word_offs(input int base, input int idx);
        return BUS_AW'(base + idx * WORD_BYTES);
    endfunction

endpackage

// File: rtl/ctlreg_bus_front.sv
module ctlreg_bus_front
    import ctlreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wen,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    input  logic [BUS_BW-1:0] be,
    input  logic [BUS_DW-1:0] rd_word,
    output logic              gnt,
    output logic              valid,
    output logic [BUS_DW-1:0] rdata,
    output bus_acc_t          acc
);

    logic ign_unused_lo;

    // Single-cycle target: every request is accepted on arrival.
    assign gnt           = req;
    assign ign_unused_lo = ^addr[1:0];

    always_comb begin
        acc.wr    = req & wen;
        acc.offs  = {addr[BUS_AW-1:2], 2'b00};
        acc.wdata = wdata;
        acc.be    = be;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            rdata <= '0;
        end else begin
            valid <= req;
            rdata <= (req && !wen) ? rd_word : '0;
        end
    end

    // R3: acknowledge follows each accepted request by one cycle
    a_r3_valid_after_req: assert property (@(posedge clk) disable iff (rst)
        req |=> valid);

    // R3: no acknowledge without a request in the previous cycle
    a_r3_valid_needs_req: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(req));

    // R3: read data is quiet outside acknowledge cycles
    a_r3_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (rdata == '0));

endmodule

// File: rtl/ctlreg_cfg_bank.sv
module ctlreg_cfg_bank
    import ctlreg_pkg::*;
#(
    parameter int N_PORT  = 4,
    parameter int N_MUL   = 4,
    parameter int N_UNIT  = 2,
    parameter int PADDR_W = 20,
    parameter int MCTL_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_acc_t          acc,
    output logic [BUS_DW-1:0] rd_word,
    output logic [PADDR_W-1:0] port_q [N_PORT],
    output logic [MCTL_W-1:0]  mul_q  [N_MUL],
    output ram_ctl_t           ram_q  [N_UNIT]
);

    localparam int MUL_BASE = mul_base(N_PORT);
    localparam int RAM_BASE = ram_base(N_PORT, N_MUL);

    logic [N_PORT-1:0] port_sel;
    logic [N_MUL-1:0]  mul_sel;
    logic [N_UNIT-1:0] ram_sel;
    logic              cfg_hit;

    always_comb begin
        for (int k = 0; k < N_PORT; k++) port_sel[k] = (acc.offs == word_offs(0, k));
        for (int k = 0; k < N_MUL; k++)  mul_sel[k]  = (acc.offs == word_offs(MUL_BASE, k));
        for (int u = 0; u < N_UNIT; u++) ram_sel[u]  = (acc.offs == word_offs(RAM_BASE, u));
        cfg_hit = (|port_sel) | (|mul_sel) | (|ram_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N_PORT; k++) port_q[k] <= '0;
            for (int k = 0; k < N_MUL; k++)  mul_q[k]  <= '0;
            for (int u = 0; u < N_UNIT; u++) ram_q[u]  <= '0;
        end else if (acc.wr) begin
            for (int k = 0; k < N_PORT; k++) begin
                if (port_sel[k])
                    port_q[k] <= PADDR_W'(lane_merge(BUS_DW'(port_q[k]), acc.wdata, acc.be));
            end
            for (int k = 0; k < N_MUL; k++) begin
                if (mul_sel[k])
                    mul_q[k] <= MCTL_W'(lane_merge(BUS_DW'(mul_q[k]), acc.wdata, acc.be));
            end
            for (int u = 0; u < N_UNIT; u++) begin
                if (ram_sel[u])
                    ram_q[u] <= ram_ctl_t'(RAM_CTL_W'(lane_merge(BUS_DW'(ram_q[u]), acc.wdata, acc.be)));
            end
        end
    end

    // Unselected words contribute nothing, so unmapped and write-only offsets read zero.
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < N_PORT; k++) if (port_sel[k]) rd_word |= BUS_DW'(port_q[k]);
        for (int k = 0; k < N_MUL; k++)  if (mul_sel[k])  rd_word |= BUS_DW'(mul_q[k]);
        for (int u = 0; u < N_UNIT; u++) if (ram_sel[u])  rd_word |= BUS_DW'(ram_q[u]);
    end

    // R6: bits above the memory-mode field never reach the read path
    a_r6_ram_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (|ram_sel) |-> (rd_word[BUS_DW-1:RAM_CTL_W] == '0));

    for (genvar k = 0; k < N_PORT; k++) begin : g_port_chk
        // R10: a write outside the register words leaves the port address untouched
        a_r10_port_kept: assert property (@(posedge clk) disable iff (rst)
            (acc.wr && !cfg_hit) |=> $stable(port_q[k]));
    end

    for (genvar k = 0; k < N_MUL; k++) begin : g_mul_chk
        // R10: a write outside the register words leaves the multiplier word untouched
        a_r10_mul_kept: assert property (@(posedge clk) disable iff (rst)
            (acc.wr && !cfg_hit) |=> $stable(mul_q[k]));
    end

endmodule

// File: rtl/ctlreg_ce_gen.sv
module ctlreg_ce_gen
    import ctlreg_pkg::*;
#(
    parameter int N_MUL   = 4,
    parameter int CE_BASE = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BUS_AW-1:0] offs,
    input  logic              be0,
    input  logic              wd0,
    output logic [N_MUL-1:0]  ce
);

    // Nothing is stored: the flop only aligns the pulse with the acknowledge.
    always_ff @(posedge clk) begin
        if (rst) begin
            ce <= '0;
        end else begin
            for (int k = 0; k < N_MUL; k++) begin
                ce[k] <= wr && be0 && wd0 && (offs == word_offs(CE_BASE, k));
            end
        end
    end

    for (genvar k = 0; k < N_MUL; k++) begin : g_ce_chk
        // R8: a pulse only ever follows a write
        a_r8_ce_from_write: assert property (@(posedge clk) disable iff (rst)
            ce[k] |-> $past(wr));
    end

endmodule

// File: rtl/ctlreg_slave.sv
module ctlreg_slave
    import ctlreg_pkg::*;
#(
    parameter int N_PORT  = 4,
    parameter int N_MUL   = 4,
    parameter int N_UNIT  = 2,
    parameter int PADDR_W = 20,
    parameter int MCTL_W  = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req,
    input  logic                        wen,
    input  logic [19:0]                 addr,
    input  logic [31:0]                 wdata,
    input  logic [3:0]                  be,
    output logic                        gnt,
    output logic                        valid,
    output logic [31:0]                 rdata,
    output logic [N_PORT*PADDR_W-1:0]   port_addr_o,
    output logic [N_MUL*MCTL_W-1:0]     mul_ctl_o,
    output logic [N_UNIT*RAM_CTL_W-1:0] ram_ctl_o,
    output logic [N_MUL-1:0]            mul_ce_o
);

    localparam int CE_BASE = ce_base(N_PORT, N_MUL, N_UNIT);

    bus_acc_t           acc;
    logic [BUS_DW-1:0]  rd_word;
    logic [PADDR_W-1:0] port_q [N_PORT];
    logic [MCTL_W-1:0]  mul_q  [N_MUL];
    ram_ctl_t           ram_q  [N_UNIT];

    ctlreg_bus_front u_front (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wen     (wen),
        .addr    (addr),
        .wdata   (wdata),
        .be      (be),
        .rd_word (rd_word),
        .gnt     (gnt),
        .valid   (valid),
        .rdata   (rdata),
        .acc     (acc)
    );

    ctlreg_cfg_bank #(
        .N_PORT  (N_PORT),
        .N_MUL   (N_MUL),
        .N_UNIT  (N_UNIT),
        .PADDR_W (PADDR_W),
        .MCTL_W  (MCTL_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .rd_word (rd_word),
        .port_q  (port_q),
        .mul_q   (mul_q),
        .ram_q   (ram_q)
    );

    ctlreg_ce_gen #(
        .N_MUL   (N_MUL),
        .CE_BASE (CE_BASE)
    ) u_ce (
        .clk  (clk),
        .rst  (rst),
        .wr   (acc.wr),
        .offs (acc.offs),
        .be0  (acc.be[0]),
        .wd0  (acc.wdata[0]),
        .ce   (mul_ce_o)
    );

    for (genvar k = 0; k < N_PORT; k++) begin : g_port_out
        assign port_addr_o[k*PADDR_W +: PADDR_W] = port_q[k];
    end
    for (genvar k = 0; k < N_MUL; k++) begin : g_mul_out
        assign mul_ctl_o[k*MCTL_W +: MCTL_W] = mul_q[k];
    end
    for (genvar u = 0; u < N_UNIT; u++) begin : g_ram_out
        assign ram_ctl_o[u*RAM_CTL_W +: RAM_CTL_W] = ram_q[u];
    end

    // R8: pulses coincide with the write acknowledge
    a_r8_ce_with_valid: assert property (@(posedge clk) disable iff (rst)
        (|mul_ce_o) |-> valid);

    // R8: at most one multiplier is pulsed per cycle
    a_r8_ce_single: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mul_ce_o));

endmodule

// File: tb/sim_ctlreg_slave.sv
module sim_ctlreg_slave;

    localparam int NP = 4, NM = 4, NU = 2, PW = 20, MW = 32, RW = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, wen = 1'b0;
    logic [19:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic gnt, valid;
    logic [31:0] rdata;
    logic [NP*PW-1:0] port_addr_o;
    logic [NM*MW-1:0] mul_ctl_o;
    logic [NU*RW-1:0] ram_ctl_o;
    logic [NM-1:0]    mul_ce_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctlreg_slave u0 (
        .clk(clk), .rst(rst), .req(req), .wen(wen), .addr(addr), .wdata(wdata), .be(be),
        .gnt(gnt), .valid(valid), .rdata(rdata), .port_addr_o(port_addr_o),
        .mul_ctl_o(mul_ctl_o), .ram_ctl_o(ram_ctl_o), .mul_ce_o(mul_ce_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [19:0] a, input logic [31:0] d,
                        input logic [3:0] b, output logic [31:0] rd,
                        output logic [3:0] ce_on, output logic [3:0] ce_after);
        @(negedge clk);
        req = 1'b1; wen = w; addr = a; wdata = d; be = b;
        #1;
        chk("R2 gnt with req", 32'(gnt), 32'd1);
        @(negedge clk);
        chk("R3 valid next cycle", 32'(valid), 32'd1);
        rd = rdata; ce_on = mul_ce_o;
        req = 1'b0; wen = 1'b0;
        @(negedge clk);
        chk("R3 valid single", 32'(valid), 32'd0);
        chk("R3 rdata idle zero", rdata, 32'd0);
        ce_after = mul_ce_o;
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d, input logic [3:0] b);
        logic [31:0] rd; logic [3:0] c1, c2;
        xfer(1'b1, a, d, b, rd, c1, c2);
        chk("R3 rdata zero on write ack", rd, 32'd0);
    endtask

    task automatic rdchk(input string tag, input logic [19:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic [3:0] c1, c2;
        xfer(1'b0, a, 32'hX, 4'hF, rd, c1, c2);
        chk(tag, rd, exp);
    endtask

    task automatic t_reset;
        chk("R1 port regs zero", 32'(|port_addr_o), 32'd0);
        chk("R1 mul regs zero", 32'(|mul_ctl_o), 32'd0);
        chk("R1 ram regs zero", 32'(ram_ctl_o), 32'd0);
        chk("R1 no pulse", 32'(mul_ce_o), 32'd0);
        chk("R1 valid low", 32'(valid), 32'd0);
        chk("R1 rdata zero", rdata, 32'd0);
        chk("R2 gnt low idle", 32'(gnt), 32'd0);
        rdchk("R1 port0 reads zero", 20'h00000, 32'd0);
        rdchk("R1 ram1 reads zero", 20'h00024, 32'd0);
    endtask

    task automatic t_port_addr;
        for (int k = 0; k < NP; k++) begin
            logic [31:0] d;
            d = 32'hABC00000 ^ (32'h12345 * (k + 1));
            wr(20'(k * 4), d, 4'hF);
            rdchk("R4 port readback", 20'(k * 4), d & 32'h000FFFFF);
            chk("R4 port output", 32'(port_addr_o[k*PW +: PW]), d & 32'h000FFFFF);
        end
    endtask

    task automatic t_mul_ctl;
        for (int k = 0; k < NM; k++) begin
            logic [31:0] d;
            d = 32'hDEAD0000 + k * 32'h01010101;
            wr(20'(16 + k * 4), d, 4'hF);
            rdchk("R5 mul readback", 20'(16 + k * 4), d);
            chk("R5 mul output", mul_ctl_o[k*MW +: MW], d);
        end
    endtask

    task automatic t_ram_ctl;
        wr(20'h00020, 32'hFFFFFFFF, 4'hF);
        rdchk("R6 ram0 upper zero", 20'h00020, 32'h00007FFF);
        chk("R6 ram0 output", 32'(ram_ctl_o[0 +: RW]), 32'h7FFF);
        wr(20'h00024, 32'h00004000, 4'hF);
        chk("R6 ram1 coef source bit14", 32'(ram_ctl_o[RW + 14]), 32'd1);
        chk("R6 ram1 other fields", 32'(ram_ctl_o[RW +: 14]), 32'd0);
        // Second-operand read width = 8-bit (10) in bits 5:4
        wr(20'h00024, 32'h00000020, 4'hF);
        rdchk("R6 ram1 width field", 20'h00024, 32'h00000020);
    endtask

    task automatic t_byte_en;
        wr(20'h00010, 32'h11223344, 4'hF);
        wr(20'h00010, 32'hAABBCCDD, 4'b0101);
        rdchk("R7 lanes 0,2 written", 20'h00010, 32'h11BB33DD);
        wr(20'h00010, 32'hFFFFFFFF, 4'b0000);
        chk("R7 no lane enabled", mul_ctl_o[0 +: MW], 32'h11BB33DD);
        wr(20'h00008, 32'h000FFFFF, 4'b1000);
        rdchk("R7 port upper lane only", 20'h00008, (32'hABC00000 ^ (32'h12345 * 3)) & 32'h000FFFFF);
    endtask

    task automatic t_ce;
        logic [31:0] rd; logic [3:0] c1, c2;
        for (int k = 0; k < NM; k++) begin
            xfer(1'b1, 20'(48 + k * 4), 32'd1, 4'h1, rd, c1, c2);
            chk("R8 pulse on matching bit", 32'(c1), 32'(1 << k));
            chk("R8 pulse lasts one cycle", 32'(c2), 32'd0);
        end
        xfer(1'b1, 20'h00030, 32'hFFFFFFFE, 4'hF, rd, c1, c2);
        chk("R8 bit0 clear gives no pulse", 32'(c1), 32'd0);
        xfer(1'b1, 20'h00034, 32'hFFFFFFFF, 4'hE, rd, c1, c2);
        chk("R8 lane0 disabled gives no pulse", 32'(c1), 32'd0);
        rdchk("R9 enable word reads zero", 20'h00030, 32'd0);
        rdchk("R9 enable word 3 reads zero", 20'h0003C, 32'd0);
    endtask

    task automatic t_unmapped;
        logic [NP*PW-1:0] p0; logic [NM*MW-1:0] m0; logic [NU*RW-1:0] r0;
        logic [31:0] rd; logic [3:0] c1, c2;
        p0 = port_addr_o; m0 = mul_ctl_o; r0 = ram_ctl_o;
        wr(20'h00028, 32'hFFFFFFFF, 4'hF);
        wr(20'h0002C, 32'hFFFFFFFF, 4'hF);
        wr(20'h00040, 32'hFFFFFFFF, 4'hF);
        wr(20'h10020, 32'hFFFFFFFF, 4'hF);
        wr(20'h10000, 32'hFFFFFFFF, 4'hF);
        wr(20'hFFFFC, 32'hFFFFFFFF, 4'hF);
        chk("R10 ports unchanged", 32'(port_addr_o != p0), 32'd0);
        chk("R10 mul unchanged", 32'(mul_ctl_o != m0), 32'd0);
        chk("R11 ram not aliased", 32'(ram_ctl_o != r0), 32'd0);
        rdchk("R10 gap reads zero", 20'h00028, 32'd0);
        rdchk("R10 high offset reads zero", 20'h00040, 32'd0);
        rdchk("R11 alias of ram0 reads zero", 20'h10020, 32'd0);
        xfer(1'b1, 20'h10030, 32'd1, 4'hF, rd, c1, c2);
        chk("R11 alias of enable gives no pulse", 32'(c1), 32'd0);
        wr(20'h00006, 32'h00055555, 4'hF);
        rdchk("R11 low address bits ignored", 20'h00004, 32'h00055555);
    endtask

    task automatic t_back2back;
        @(negedge clk);
        req = 1'b1; wen = 1'b1; addr = 20'h00014; wdata = 32'h0BADF00D; be = 4'hF;
        @(negedge clk);
        chk("R3 valid for write in stream", 32'(valid), 32'd1);
        chk("R3 rdata zero for write ack", rdata, 32'd0);
        wen = 1'b0;
        @(negedge clk);
        chk("R3 valid for read in stream", 32'(valid), 32'd1);
        chk("R5 read after write sees new value", rdata, 32'h0BADF00D);
        req = 1'b0;
        @(negedge clk);
        chk("R3 valid drops after stream", 32'(valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_port_addr;
        t_mul_ctl;
        t_ram_ctl;
        t_byte_en;
        t_ce;
        t_unmapped;
        t_back2back;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule